// File: doc/BRIEF.md
# Buffered CPU Port for Video Memory

This block is the processor-facing side of a video controller's memory port. The processor loads a memory address by writing two bytes to a control port. It then moves bytes through a data port. A single byte register stands between the processor and video memory. A data write is parked in that register and leaves for memory later. In read mode the register is filled ahead of time, so a data read can be answered at once.

Video memory is reached only when the built-in scheduler opens an access slot. Slots come more often in the text display mode than in the graphics modes. There is no wait line back to the processor. Software has to leave enough time between accesses. A read that arrives before the read-ahead has landed returns whatever the register held before.

The memory side is a request/acknowledge pair. A request starts on a slot and stays up until the memory acknowledges it. Only one transaction is in flight at a time.

Top module: `vramCpuPort`

## Requirements
- R1: After reset, `vramReq` is 0, `overrun` is 0 and `cpuRdData` is 0x00.
- R2: Address setup is two control-port writes (`cpuSel`=1). The first write supplies address bits 7:0. The second supplies bits 13:8 in its bits 5:0, and its bit 6 selects write mode (1) or read mode (0).
- R3: In write mode, a data write (`cpuSel`=0) made right after setup is accepted. At the next free slot the byte is sent to memory at the setup address, with `vramWe`=1.
- R4: A read-mode setup starts a read-ahead of the setup address. Once it completes, a data read returns that memory byte.
- R5: A data read returns the buffer contents in the same cycle. A read made before the read-ahead completes returns the previous buffer contents.
- R6: Each completed memory access advances the address by one. The address wraps from 0x3FFF to 0x0000.
- R7: In read mode, each data read starts a new read-ahead from the advanced address.
- R8: A data write that arrives while an earlier written byte is still waiting for a slot replaces that byte and sets `overrun` to 1. Only the newer byte reaches memory. The next completed address setup clears `overrun`.
- R9: A request may start only on a slot. Slots come every 4 clocks when `textMode`=1 (3 per 12-clock window) and every 6 clocks when `textMode`=0 (2 per window).
- R10: `vramReq` stays high with a stable `vramAddr` until `vramAck`, and it drops on the clock after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | Processor write strobe, one cycle per access |
| cpuRdEn | input | 1 | Processor read strobe, one cycle per access |
| cpuSel | input | 1 | 1 = control port, 0 = data port |
| cpuWrData | input | 8 | Processor write byte |
| cpuRdData | output | 8 | Buffer byte returned on data reads |
| textMode | input | 1 | 1 = text display mode (denser slots) |
| vramReq | output | 1 | Memory request |
| vramWe | output | 1 | Request is a write |
| vramAddr | output | 14 | Request address |
| vramWrData | output | 8 | Request write byte |
| vramRdData | input | 8 | Memory read byte, valid with acknowledge |
| vramAck | input | 1 | Memory acknowledge |
| overrun | output | 1 | A waiting write byte was replaced |

## Verification
The bench reads immediately after a read-mode setup, which has to return the old buffer byte. A design that stalled or bypassed the buffer would return fresh memory data there instead. Two back-to-back data writes test the replace-and-flag path. A design that queued the writes would put both bytes in memory and leave `overrun` low. Writing across address 0x3FFF catches an increment that does not wrap or that spills into a wider field. Measuring the spacing of request edges under each mode catches a scheduler with the wrong period, or one that ignores `textMode`.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_BIT = 6;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} pendOp_t;

  typedef struct packed {
    logic ldLow;
    logic ldAddr;
    logic ldBuf;
    logic issue;
    logic incAddr;
    logic ldRead;
  } dpStrobe_t;
endpackage

// File: rtl/vcpSlotTimer.sv
module vcpSlotTimer #(
  parameter int WINDOW_CYC = 12,
  parameter int TEXT_SLOTS = 3,
  parameter int GFX_SLOTS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic textMode,
  output logic slot
);
  localparam int TEXT_PER = WINDOW_CYC / TEXT_SLOTS;
  localparam int GFX_PER = WINDOW_CYC / GFX_SLOTS;
  localparam int MAX_PER = (TEXT_PER > GFX_PER) ? TEXT_PER : GFX_PER;
  localparam int CNT_W = $clog2(MAX_PER + 1);
  localparam logic [CNT_W-1:0] TEXT_LAST = CNT_W'(TEXT_PER - 1);
  localparam logic [CNT_W-1:0] GFX_LAST = CNT_W'(GFX_PER - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  assign lastCnt = textMode ? TEXT_LAST : GFX_LAST;
  assign slot = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (cnt >= lastCnt) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  // Slots are never adjacent, since each period is at least two clocks.
  assert_slot_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    slot |=> !slot);
endmodule

// File: rtl/vcpCtrl.sv
module vcpCtrl
  import vcp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuWrEn,
  input  logic      cpuRdEn,
  input  logic      cpuSel,
  input  logic      modeBit,
  input  logic      slot,
  input  logic      vramAck,
  output dpStrobe_t strb,
  output logic      vramReq,
  output logic      vramWe,
  output logic      overrun
);
  logic     hiPhase;
  logic     wrMode;
  logic     stale;
  pendOp_t  pendOp;
  logic     ctlWr, datWr, datRd, cpuAny, issueOk, ackDone, keep;

  always_comb begin
    ctlWr   = cpuWrEn && cpuSel;
    datWr   = cpuWrEn && !cpuSel;
    datRd   = cpuRdEn && !cpuSel;
    cpuAny  = cpuWrEn || cpuRdEn;
    issueOk = slot && (pendOp != OP_NONE) && !vramReq && !cpuAny;
    ackDone = vramReq && vramAck;
    strb = '0;
    strb.ldLow  = ctlWr && !hiPhase;
    strb.ldAddr = ctlWr && hiPhase;
    strb.ldBuf  = datWr;
    strb.issue  = issueOk;
    keep = ackDone && !stale && !strb.ldAddr;
    strb.incAddr = keep;
    strb.ldRead  = keep && !vramWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPhase <= 1'b0;
      wrMode  <= 1'b0;
      stale   <= 1'b0;
      pendOp  <= OP_NONE;
      vramReq <= 1'b0;
      vramWe  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (ctlWr) hiPhase <= !hiPhase;

      if (strb.ldAddr) begin
        wrMode  <= modeBit;
        overrun <= 1'b0;
        pendOp  <= modeBit ? OP_NONE : OP_RD;
      end else if (datWr) begin
        if (pendOp == OP_WR) overrun <= 1'b1;
        pendOp <= OP_WR;
      end else if (datRd && !wrMode && pendOp != OP_WR) begin
        pendOp <= OP_RD;
      end else if (issueOk) begin
        pendOp <= OP_NONE;
      end

      // A transaction that is in flight when the address is reloaded must not
      // touch the new address or the buffer.
      if (strb.ldAddr) stale <= vramReq && !vramAck;
      else if (ackDone) stale <= 1'b0;

      if (issueOk) begin
        vramReq <= 1'b1;
        vramWe  <= (pendOp == OP_WR);
      end else if (ackDone) begin
        vramReq <= 1'b0;
      end
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vramReq && !vramAck) |=> vramReq);
  assert_req_on_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vramReq) |-> $past(slot));
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(cpuWrEn && !cpuSel));
  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vramReq && vramAck) |=> !vramReq);
endmodule

// File: rtl/vcpDatapath.sv
module vcpDatapath
  import vcp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] vramRdData,
  input  logic              vramReq,
  input  logic              vramAck,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [DATA_W-1:0] vramWrData
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [DATA_W-1:0] lowByte;
  logic [DATA_W-1:0] bufByte;
  logic [ADDR_W-1:0] addr;

  assign cpuRdData = bufByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowByte    <= '0;
      bufByte    <= '0;
      addr       <= '0;
      vramAddr   <= '0;
      vramWrData <= '0;
    end else begin
      if (strb.ldLow) lowByte <= cpuWrData;
      if (strb.ldAddr) addr <= {cpuWrData[HI_W-1:0], lowByte};
      else if (strb.incAddr) addr <= addr + ADDR_ONE;
      if (strb.ldBuf) bufByte <= cpuWrData;
      else if (strb.ldRead) bufByte <= vramRdData;
      if (strb.issue) begin
        vramAddr   <= addr;
        vramWrData <= bufByte;
      end
    end
  end

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vramReq && !vramAck) |=> $stable(vramAddr));
  assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vramReq && !vramAck) |=> $stable(vramWrData));
endmodule

// File: rtl/vramCpuPort.sv
module vramCpuPort
  import vcp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int WINDOW_CYC = 12,
  parameter int TEXT_SLOTS = 3,
  parameter int GFX_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic              cpuRdEn,
  input  logic              cpuSel,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              textMode,
  output logic              vramReq,
  output logic              vramWe,
  output logic [ADDR_W-1:0] vramAddr,
  output logic [DATA_W-1:0] vramWrData,
  input  logic [DATA_W-1:0] vramRdData,
  input  logic              vramAck,
  output logic              overrun
);
  dpStrobe_t strb;
  logic slot;

  vcpSlotTimer #(.WINDOW_CYC(WINDOW_CYC), .TEXT_SLOTS(TEXT_SLOTS), .GFX_SLOTS(GFX_SLOTS)) uTimer (
    .clk(clk), .rstN(rstN), .textMode(textMode), .slot(slot));

  vcpCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuSel(cpuSel),
    .modeBit(cpuWrData[MODE_BIT]), .slot(slot), .vramAck(vramAck), .strb(strb),
    .vramReq(vramReq), .vramWe(vramWe), .overrun(overrun));

  vcpDatapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWrData(cpuWrData), .vramRdData(vramRdData),
    .vramReq(vramReq), .vramAck(vramAck), .cpuRdData(cpuRdData), .vramAddr(vramAddr),
    .vramWrData(vramWrData));
endmodule

// File: tb/sim_vramCpuPort.sv
`timescale 1ns/1ps
module sim_vramCpuPort;
  logic clk = 1'b0, rstN = 1'b0;
  logic cpuWrEn = 1'b0, cpuRdEn = 1'b0, cpuSel = 1'b0, textMode = 1'b0;
  logic [7:0] cpuWrData = '0, vramRdData = '0, vramWrData, cpuRdData;
  logic vramReq, vramWe, vramAck = 1'b0, overrun;
  logic [13:0] vramAddr;
  logic [7:0] mem [0:255];
  int checks = 0, fails = 0, cyc = 0, riseCnt = 0, riseCyc = 0;
  logic prevReq = 1'b0, lastWe = 1'b0;
  logic [13:0] lastAddr = '0;

  always #2.5 clk = ~clk;

  vramCpuPort u0 (.clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuRdEn(cpuRdEn), .cpuSel(cpuSel),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .textMode(textMode), .vramReq(vramReq),
    .vramWe(vramWe), .vramAddr(vramAddr), .vramWrData(vramWrData), .vramRdData(vramRdData),
    .vramAck(vramAck), .overrun(overrun));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prevReq <= vramReq;
    if (vramReq && !prevReq) begin
      lastAddr <= vramAddr; lastWe <= vramWe; riseCyc <= cyc; riseCnt <= riseCnt + 1;
    end
    if (!rstN) vramAck <= 1'b0;
    else begin
      vramAck <= vramReq && !vramAck;
      if (vramReq && !vramAck) begin
        if (vramWe) mem[vramAddr[7:0]] <= vramWrData;
        vramRdData <= mem[vramAddr[7:0]];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cpuWr(input logic sel, input logic [7:0] d);
    @(negedge clk); cpuWrEn = 1'b1; cpuSel = sel; cpuWrData = d;
    @(negedge clk); cpuWrEn = 1'b0;
  endtask

  task automatic cpuRd(output logic [7:0] d);
    @(negedge clk); cpuRdEn = 1'b1; cpuSel = 1'b0; d = cpuRdData;
    @(negedge clk); cpuRdEn = 1'b0;
  endtask

  task automatic setAddr(input logic [13:0] a, input logic wr);
    cpuWr(1'b1, a[7:0]);
    cpuWr(1'b1, {1'b0, wr, a[13:8]});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRise();
    int start = riseCnt;
    while (riseCnt == start) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 req", int'(vramReq), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 rdData", int'(cpuRdData), 0);
  endtask

  task automatic testWrite();
    setAddr(14'h0010, 1'b1);
    cpuWr(1'b0, 8'hA5);
    waitRise();
    chk("R3 we", int'(lastWe), 1);
    chk("R2 addr", int'(lastAddr), 'h10);
    chk("R10 req held", int'(vramReq), 1);
    @(negedge clk);
    chk("R10 req dropped", int'(vramReq), 0);
    chk("R3 mem", int'(mem[8'h10]), 'hA5);
    cpuWr(1'b0, 8'h5A);
    idle(20);
    chk("R6 next addr", int'(mem[8'h11]), 'h5A);
  endtask

  task automatic testRead();
    logic [7:0] d;
    mem[8'h20] = 8'h11; mem[8'h21] = 8'h22; mem[8'h22] = 8'h33; mem[8'h23] = 8'h44;
    setAddr(14'h0020, 1'b0);
    idle(20);
    cpuRd(d); chk("R4 prefetch", int'(d), 'h11);
    idle(20);
    cpuRd(d); chk("R7 next read", int'(d), 'h22);
    idle(20);
    cpuRd(d); chk("R7 third read", int'(d), 'h33);
    idle(20);
  endtask

  task automatic testStale();
    logic [7:0] d;
    mem[8'h30] = 8'h99;
    setAddr(14'h0030, 1'b0);
    cpuRd(d); chk("R5 stale", int'(d), 'h44);
    idle(20);
    cpuRd(d); chk("R5 settled", int'(d), 'h99);
    idle(20);
  endtask

  task automatic testWrap();
    setAddr(14'h3FFF, 1'b1);
    cpuWr(1'b0, 8'h77); idle(20);
    chk("R6 top addr", int'(lastAddr), 'h3FFF);
    cpuWr(1'b0, 8'h88); idle(20);
    chk("R6 wrap addr", int'(lastAddr), 0);
    chk("R6 wrap data", int'(mem[8'h00]), 'h88);
    chk("R6 top data", int'(mem[8'hFF]), 'h77);
  endtask

  task automatic testOverrun();
    mem[8'h40] = 8'h00; mem[8'h41] = 8'hEE;
    setAddr(14'h0040, 1'b1);
    @(negedge clk); cpuWrEn = 1'b1; cpuSel = 1'b0; cpuWrData = 8'hC1;
    @(negedge clk); cpuWrData = 8'hC2;
    @(negedge clk); cpuWrEn = 1'b0;
    chk("R8 flag set", int'(overrun), 1);
    idle(20);
    chk("R8 newer byte", int'(mem[8'h40]), 'hC2);
    chk("R8 single write", int'(mem[8'h41]), 'hEE);
    setAddr(14'h0050, 1'b1);
    chk("R8 flag cleared", int'(overrun), 0);
  endtask

  task automatic measure(input logic tm, input int per);
    int t0;
    textMode = tm;
    setAddr(14'h0060, 1'b1);
    cpuWr(1'b0, 8'h01);
    waitRise(); cpuWr(1'b0, 8'h02);
    t0 = riseCyc;
    waitRise(); chk("R9 period a", riseCyc - t0, per);
    t0 = riseCyc; cpuWr(1'b0, 8'h03);
    waitRise(); chk("R9 period b", riseCyc - t0, per);
    idle(20);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    idle(4);
    testReset();
    @(negedge clk); rstN = 1'b1;
    testWrite();
    testRead();
    testStale();
    testWrap();
    testOverrun();
    measure(1'b1, 4);
    measure(1'b0, 6);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule